// File: doc/BRIEF.md
# Shared-Adder Arithmetic and Logic Unit

This block is a combinational arithmetic and logic unit in which every operation, the bitwise ones included, passes through a single adder. A 4-bit opcode is decoded into a handful of operand controls. Operand A can be forced to all ones, forced to zero, or inverted. Operand B can be forced to zero or inverted. A carry-in is also chosen. The conditioned operands drive one adder. Its bitwise half-sum (A xor B) and carry-generate (A and B) vectors are taken out next to the sum. A 2-bit output select then picks the sum, the half-sum, the generate vector, or their exclusive-or, which equals A or B.

There is no clock and no state. The result and the carry-out settle from the inputs within the same cycle, so the unit sits directly in an execute stage. The width is a parameter and defaults to 32 bits.

Top module: `alu_reuse_core`

## Requirements
- R1: Opcode 4'h0 (add) returns A + B modulo 2^WIDTH, and the carry-out is the carry out of the top bit.
- R2: Opcode 4'h1 (subtract) returns A - B modulo 2^WIDTH. The carry-out is 1 exactly when A >= B as unsigned numbers.
- R3: Opcode 4'h2 (increment) returns A + 1, with carry-out 1 only when A is all ones. Opcode 4'h3 (decrement) returns A - 1, with carry-out 1 unless A is zero.
- R4: Opcode 4'hB (negate) returns the two's complement of A, with carry-out 1 only when A is zero.
- R5: Opcodes 4'h4, 4'h5, 4'h6 and 4'hC return A and B, A or B, A xor B, and A and not B.
- R6: Opcodes 4'h7, 4'h8, 4'h9 and 4'hA return not A, not (A and B), not (A or B), and not (A xor B).
- R7: Opcode 4'hD returns B unchanged, and opcode 4'hE returns all ones, whatever the operands are.
- R8: Opcode 4'hF is unused and returns zero with carry-out 0 for any operands.
- R9: The carry-out is 0 for every opcode that selects a bitwise output (4'h4 to 4'hA and 4'hC to 4'hF).
- R10: The result and the carry-out follow a change of opcode or operands with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| result_o | output | WIDTH | Selected result |
| carry_o | output | 1 | Adder carry out of the top bit, 0 for bitwise outputs |

## Verification
The bench builds two copies of the unit. One has WIDTH set to 4. At that width every pair of operands under all sixteen opcodes can be swept, so every carry boundary (wrap of increment, borrow of subtract, negation of zero) is reached exhaustively. The second copy uses the default 32 bits. It takes directed corner operands (zero, one, all ones, sign bit alone, largest positive, a mixed pattern) under every opcode, which exercises carries that ripple across the full width. For these checks the inputs change with no clock edge in between.

// File: rtl/alu_reuse_pkg.sv
// Shared types for the shared-adder ALU: opcode values, output select
// codes and the decoded control bundle.
package alu_reuse_pkg;

    // Opcode values seen at the op_i port.
    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_INC  = 4'h2,
        OP_DEC  = 4'h3,
        OP_AND  = 4'h4,
        OP_OR   = 4'h5,
        OP_XOR  = 4'h6,
        OP_NOTA = 4'h7,
        OP_NAND = 4'h8,
        OP_NOR  = 4'h9,
        OP_XNOR = 4'hA,
        OP_NEG  = 4'hB,
        OP_ANDN = 4'hC,
        OP_PASB = 4'hD,
        OP_ONES = 4'hE,
        OP_IDLE = 4'hF
    } alu_op_e;

    // Output select: which adder vector leaves the unit.
    typedef enum logic [1:0] {
        SEL_SUM  = 2'b00,
        SEL_PROP = 2'b01,
        SEL_GEN  = 2'b10,
        SEL_ANY  = 2'b11
    } out_sel_e;

    // Controls for the conditioning stages, the adder and the output select.
    typedef struct packed {
        logic     a_set;
        logic     a_clr;
        logic     a_inv;
        logic     b_clr;
        logic     b_inv;
        logic     cin;
        out_sel_e sel;
    } alu_ctrl_t;

    localparam alu_ctrl_t CTRL_NONE = '{a_set: 1'b0, a_clr: 1'b0, a_inv: 1'b0,
                                        b_clr: 1'b0, b_inv: 1'b0, cin: 1'b0,
                                        sel: SEL_SUM};

endpackage

// File: rtl/alu_op_decode.sv
// Opcode decoder.
// Turns the 4-bit opcode into conditioning controls, the carry-in and the
// output select. It assumes the opcode is stable for the whole evaluation;
// it holds no state.
module alu_op_decode
    import alu_reuse_pkg::*;
(
    input  logic [3:0] op_i,
    output alu_ctrl_t  ctrl_o
);

    // Table of control settings, one entry per opcode.
    always_comb begin
        ctrl_o = CTRL_NONE;
        case (alu_op_e'(op_i))
            OP_ADD:  ctrl_o.sel = SEL_SUM;
            OP_SUB:  begin ctrl_o.b_inv = 1'b1; ctrl_o.cin = 1'b1; end
            OP_INC:  begin ctrl_o.b_clr = 1'b1; ctrl_o.cin = 1'b1; end
            OP_DEC:  begin ctrl_o.b_clr = 1'b1; ctrl_o.b_inv = 1'b1; end
            OP_AND:  ctrl_o.sel = SEL_GEN;
            OP_OR:   ctrl_o.sel = SEL_ANY;
            OP_XOR:  ctrl_o.sel = SEL_PROP;
            OP_NOTA: begin
                ctrl_o.a_inv = 1'b1; ctrl_o.b_clr = 1'b1; ctrl_o.sel = SEL_PROP;
            end
            OP_NAND: begin
                ctrl_o.a_inv = 1'b1; ctrl_o.b_inv = 1'b1; ctrl_o.sel = SEL_ANY;
            end
            OP_NOR:  begin
                ctrl_o.a_inv = 1'b1; ctrl_o.b_inv = 1'b1; ctrl_o.sel = SEL_GEN;
            end
            OP_XNOR: begin ctrl_o.a_inv = 1'b1; ctrl_o.sel = SEL_PROP; end
            OP_NEG:  begin
                ctrl_o.a_inv = 1'b1; ctrl_o.b_clr = 1'b1; ctrl_o.cin = 1'b1;
            end
            OP_ANDN: begin ctrl_o.b_inv = 1'b1; ctrl_o.sel = SEL_GEN; end
            OP_PASB: begin ctrl_o.a_clr = 1'b1; ctrl_o.sel = SEL_PROP; end
            OP_ONES: begin
                ctrl_o.a_set = 1'b1; ctrl_o.b_clr = 1'b1; ctrl_o.sel = SEL_PROP;
            end
            default: begin
                ctrl_o.a_clr = 1'b1; ctrl_o.b_clr = 1'b1; ctrl_o.sel = SEL_PROP;
            end
        endcase
    end

endmodule

// File: rtl/alu_operand_cond.sv
// Operand conditioning stage.
// It forces the operand to zero or, when HAS_SET is 1, to all ones. It then
// optionally inverts it. Clear wins over set, and the inversion acts on the
// forced value, so clear plus invert gives all ones. With HAS_SET = 0 the
// set input is ignored.
module alu_operand_cond #(
    parameter int WIDTH   = 32,
    parameter bit HAS_SET = 1'b1
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic             inv_i,
    output logic [WIDTH-1:0] opnd_o
);

    logic [WIDTH-1:0] forced;

    generate
        if (HAS_SET) begin : g_set_clr
            // Force stage with both set and clear, clear taking priority.
            always_comb begin
                if (clr_i)      forced = '0;
                else if (set_i) forced = '1;
                else            forced = opnd_i;
            end
        end else begin : g_clr_only
            logic unused_set;
            assign unused_set = set_i;
            // Force stage with clear only.
            always_comb forced = clr_i ? '0 : opnd_i;
        end
    endgenerate

    // Inversion after the force stage.
    always_comb opnd_o = inv_i ? ~forced : forced;

endmodule

// File: rtl/alu_shared_adder.sv
// The one adder of the unit.
// It gives the sum, the carry out of the top bit and its bitwise half-sum
// and generate vectors, which serve as the logic results.
module alu_shared_adder #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o,
    output logic [WIDTH-1:0] prop_o,
    output logic [WIDTH-1:0] gen_o
);

    localparam int EXT = WIDTH + 1;

    logic [EXT-1:0] total;

    // Full-width addition with the carry bit widened in place.
    always_comb total = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};

    // Split the sum and form the bitwise vectors.
    always_comb begin
        sum_o  = total[WIDTH-1:0];
        cout_o = total[WIDTH];
        prop_o = x_i ^ y_i;
        gen_o  = x_i & y_i;
    end

endmodule

// File: rtl/alu_reuse_core.sv
// Shared-adder ALU, top level.
// Decoder, two conditioning stages, one adder and an output select. It is
// purely combinational. The carry-out is passed on only when the sum is
// selected.
module alu_reuse_core
    import alu_reuse_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [3:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);

    alu_ctrl_t        ctrl;
    logic [WIDTH-1:0] a_cond, b_cond, sum, prop, gen;
    logic             cout;

    alu_op_decode u_dec (.op_i(op_i), .ctrl_o(ctrl));

    alu_operand_cond #(.WIDTH(WIDTH), .HAS_SET(1'b1)) u_cond_a (
        .opnd_i(a_i), .set_i(ctrl.a_set), .clr_i(ctrl.a_clr),
        .inv_i(ctrl.a_inv), .opnd_o(a_cond));

    alu_operand_cond #(.WIDTH(WIDTH), .HAS_SET(1'b0)) u_cond_b (
        .opnd_i(b_i), .set_i(1'b0), .clr_i(ctrl.b_clr),
        .inv_i(ctrl.b_inv), .opnd_o(b_cond));

    alu_shared_adder #(.WIDTH(WIDTH)) u_add (
        .x_i(a_cond), .y_i(b_cond), .cin_i(ctrl.cin),
        .sum_o(sum), .cout_o(cout), .prop_o(prop), .gen_o(gen));

    // Output select; the carry leaves only with the sum.
    always_comb begin
        carry_o = 1'b0;
        case (ctrl.sel)
            SEL_SUM:  begin result_o = sum; carry_o = cout; end
            SEL_PROP: result_o = prop;
            SEL_GEN:  result_o = gen;
            default:  result_o = prop ^ gen;
        endcase
    end

    // Reference values for the port checks below.
    logic [WIDTH:0] chk_add;
    logic [WIDTH-1:0] chk_sub;
    always_comb begin
        chk_add = {1'b0, a_i} + {1'b0, b_i};
        chk_sub = a_i - b_i;
    end

    // Port-level checks of the whole decode-condition-add-select path.
    always_comb begin
        if (op_i == OP_ADD)
            assert_add_sum_R1: assert ({carry_o, result_o} == chk_add);
        if (op_i == OP_SUB)
            assert_sub_borrow_R2: assert (result_o == chk_sub && carry_o == (a_i >= b_i));
        if (op_i == OP_XOR)
            assert_xor_path_R5: assert (result_o == (a_i ^ b_i));
        if (op_i == OP_IDLE)
            assert_idle_zero_R8: assert (result_o == '0 && !carry_o);
        if (op_i >= OP_AND && op_i != OP_NEG)
            assert_logic_no_carry_R9: assert (!carry_o);
    end

endmodule

// File: tb/alu_reuse_core_test.sv
// Bench: exhaustive sweep at WIDTH 4, directed corners at WIDTH 32.
module alu_reuse_core_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0]  n_op = 4'hF;
    logic [3:0]  n_a = '0, n_b = '0;
    logic [3:0]  n_res;
    logic        n_c;

    logic [3:0]  w_op = 4'hF;
    logic [31:0] w_a = '0, w_b = '0;
    logic [31:0] w_res;
    logic        w_c;

    alu_reuse_core #(.WIDTH(4)) uut (
        .op_i(n_op), .a_i(n_a), .b_i(n_b), .result_o(n_res), .carry_o(n_c));

    alu_reuse_core #(.WIDTH(32)) uut_wide (
        .op_i(w_op), .a_i(w_a), .b_i(w_b), .result_o(w_res), .carry_o(w_c));

    // Expected {carry, result} computed arithmetically for width n.
    function automatic logic [32:0] model(input logic [3:0] op,
                                          input logic [31:0] a,
                                          input logic [31:0] b, input int n);
        logic [63:0] m, x, y, s;
        logic        arith;
        m = (64'd1 << n) - 64'd1;
        x = {32'd0, a} & m;
        y = {32'd0, b} & m;
        arith = 1'b1;
        case (op)
            4'h0: s = x + y;
            4'h1: s = x + (~y & m) + 64'd1;
            4'h2: s = x + 64'd1;
            4'h3: s = x + m;
            4'hB: s = (~x & m) + 64'd1;
            default: begin
                arith = 1'b0;
                case (op)
                    4'h4: s = x & y;
                    4'h5: s = x | y;
                    4'h6: s = x ^ y;
                    4'h7: s = ~x;
                    4'h8: s = ~(x & y);
                    4'h9: s = ~(x | y);
                    4'hA: s = ~(x ^ y);
                    4'hC: s = x & ~y;
                    4'hD: s = y;
                    4'hE: s = m;
                    default: s = 64'd0;
                endcase
            end
        endcase
        model = {arith & s[n], s[31:0] & m[31:0]};
    endfunction

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'h0: req_of = "R1";
            4'h1: req_of = "R2";
            4'h2, 4'h3: req_of = "R3";
            4'hB: req_of = "R4";
            4'h4, 4'h5, 4'h6, 4'hC: req_of = "R5";
            4'h7, 4'h8, 4'h9, 4'hA: req_of = "R6";
            4'hD, 4'hE: req_of = "R7";
            default: req_of = "R8";
        endcase
    endfunction

    function automatic logic [31:0] corner(input int i);
        case (i)
            0: corner = 32'h0000_0000;
            1: corner = 32'h0000_0001;
            2: corner = 32'hFFFF_FFFF;
            3: corner = 32'h8000_0000;
            4: corner = 32'h7FFF_FFFF;
            default: corner = 32'h1234_5678;
        endcase
    endfunction

    task automatic check(input string req, input logic [32:0] act,
                         input logic [32:0] exp, input logic [3:0] op);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s op=%h actual=%h expected=%h", req, op, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Initial state: unused opcode with zero operands gives zero (R8).
        @(negedge clk);
        check("R8", {n_c, 28'd0, n_res}, 33'd0, n_op);

        // Exhaustive sweep at width 4, one vector per clock, sampled mid-cycle.
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    @(posedge clk);
                    n_op = op[3:0]; n_a = a[3:0]; n_b = b[3:0];
                    @(negedge clk);
                    check(req_of(op[3:0]), {n_c, 28'd0, n_res},
                          model(op[3:0], {28'd0, a[3:0]}, {28'd0, b[3:0]}, 4),
                          op[3:0]);
                    // Bitwise opcodes never raise the carry (R9).
                    if (op >= 4 && op != 11)
                        check("R9", {32'd0, n_c}, 33'd0, op[3:0]);
                end
            end
        end

        // Directed corners at width 32. Inputs change and are read 1 ns
        // later with no clock edge between (R10).
        @(negedge clk);
        for (int op = 0; op < 16; op++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    w_op = op[3:0]; w_a = corner(i); w_b = corner(j);
                    #1;
                    check("R10", {w_c, w_res},
                          model(op[3:0], corner(i), corner(j), 32), op[3:0]);
                end
            end
        end
        done = 1'b1;
        summary();
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish");
            summary();
        end
    end

endmodule